// File: doc/BRIEF.md
# Decode-Stage Branch Predictor

This block guesses the direction of control transfers for a short in-order pipeline. It sits beside the decode stage. It looks at the instruction being decoded: its PC, a two-bit class code and its signed immediate offset. From these it decides in the same cycle whether fetch should be steered to the computed target. A later stage reports each resolved transfer back through a resolve port. The port carries the transfer's PC, its real direction, its real target and the direction that was predicted for it. When the guess was wrong, the block raises a flush with the correct next PC.

A run-time mode input selects the policy. In the off mode the block never steers fetch, so every taken transfer is paid for at resolution. In the static mode a JAL always steers. A conditional branch steers when its offset is negative, which is the usual shape of a loop. In the dynamic mode a JAL still always steers. A conditional branch follows a direct-mapped table of 2-bit saturating counters. The table holds 2^HIST_LOG2 entries and is indexed by the PC bits above the word offset. A taken prediction whose target is not 4-byte aligned raises a trap and does not steer fetch. The resolve side applies the same rule to the real target.

The parameter EARLY_RESOLVE models resolution one stage earlier. It removes the register on the flush path, so the flush appears one cycle sooner.

Top module: `dec_branch_predictor`

## Requirements
- R1: With mode_i equal to 0 (off) or 3 (reserved, treated as off), redir_o, pred_taken_o and trap_o stay low for any decode input.
- R2: In mode 1 (static), a valid class-1 (conditional) instruction is predicted taken exactly when bit AW-1 of dec_imm_i is set. A taken prediction with an aligned target steers to dec_pc_i + dec_imm_i.
- R3: In modes 1 and 2, a valid class-2 (JAL) instruction is always predicted taken and steers to dec_pc_i + dec_imm_i when that target is aligned.
- R4: When dec_valid_i is low, or the class is 0 (other) or 3, no prediction, redirect or trap is produced.
- R5: In mode 2 (dynamic), a valid conditional instruction is predicted taken when bit 1 of the counter at index dec_pc_i[HIST_LOG2+1:2] is set. All counters leave reset at 01 (weakly not taken).
- R6: A resolve with rsv_valid_i and rsv_cond_i high moves the counter at rsv_pc_i[HIST_LOG2+1:2] up by one when taken (saturating at 11) or down by one when not taken (saturating at 00). A resolve with rsv_cond_i low leaves every counter unchanged. Updates happen in every mode.
- R7: A counter write and a read of the same index in the same cycle return the value the counter held before the write.
- R8: A taken prediction whose target has bits [1:0] nonzero raises trap_o and keeps redir_o low. redir_o never comes with a misaligned redir_pc_o.
- R9: A valid resolve whose actual direction differs from rsv_pred_i raises flush_o. flush_pc_o is rsv_target_i when taken and rsv_pc_i + 4 when not taken. With EARLY_RESOLVE = 0 this shows one cycle after the resolve; with EARLY_RESOLVE = 1 it shows in the same cycle.
- R10: A mispredicted resolve that was actually taken to a target with bits [1:0] nonzero raises rsv_trap_o instead of flush_o, with the same latency as R9.
- R11: A valid resolve whose direction matches rsv_pred_i, or no valid resolve, raises neither flush_o nor rsv_trap_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 off, 1 static, 2 dynamic, 3 treated as off |
| dec_valid_i | input | 1 | Decode slot holds an instruction |
| dec_kind_i | input | 2 | 0 other, 1 conditional branch, 2 JAL, 3 other |
| dec_pc_i | input | AW | PC of the decoded instruction |
| dec_imm_i | input | AW | Sign-extended immediate offset |
| redir_o | output | 1 | Steer fetch to redir_pc_o |
| redir_pc_o | output | AW | Predicted target |
| pred_taken_o | output | 1 | Predicted direction, carried to the resolving stage |
| trap_o | output | 1 | Predicted-taken target misaligned |
| rsv_valid_i | input | 1 | Resolve port holds a transfer |
| rsv_cond_i | input | 1 | Resolved transfer is a conditional branch |
| rsv_pc_i | input | AW | PC of the resolved transfer |
| rsv_taken_i | input | 1 | Actual direction |
| rsv_pred_i | input | 1 | Direction predicted at decode |
| rsv_target_i | input | AW | Actual target |
| flush_o | output | 1 | Misprediction: restart at flush_pc_o |
| flush_pc_o | output | AW | Correct next PC |
| rsv_trap_o | output | 1 | Actual taken target misaligned on a mispredict |

## Verification
A corrupted counter cannot be seen directly. It shows up only when a dynamic-mode conditional branch maps to that entry. Then it shows as a wrong pred_taken_o and redir_o in that same decode cycle. Counter state is therefore rebuilt in a bench model from every resolve and compared on each later decode, including decodes that fall in the same cycle as a write. A broken flush path shows one cycle after the resolve, as a missing or extra flush_o, a wrong flush_pc_o, or a trap raised in place of a flush.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

   typedef enum logic [1:0] {
      MODE_OFF     = 2'd0,
      MODE_STATIC  = 2'd1,
      MODE_DYNAMIC = 2'd2,
      MODE_SPARE   = 2'd3
   } pred_mode_e;

   typedef enum logic [1:0] {
      KIND_OTHER = 2'd0,
      KIND_COND  = 2'd1,
      KIND_JAL   = 2'd2,
      KIND_SPARE = 2'd3
   } insn_kind_e;

   localparam int unsigned CTR_W = 2;
   localparam logic [CTR_W-1:0] CTR_INIT = 2'b01;

   // saturating step of a direction counter
   function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] c,
                                                 input logic taken);
      logic [CTR_W-1:0] n;
      if (taken) n = (c == '1) ? c : c + 1'b1;
      else       n = (c == '0) ? c : c - 1'b1;
      return n;
   endfunction

endpackage

// File: rtl/dbp_history.sv
module dbp_history
   import dbp_pkg::*;
#(
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic             rd_taken_o,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic             wr_taken_i
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [CTR_W-1:0] ctr_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int e = 0; e < DEPTH; e++) ctr_q[e] <= CTR_INIT;
      end else if (wr_en_i) begin
         ctr_q[wr_idx_i] <= ctr_step(ctr_q[wr_idx_i], wr_taken_i);
      end
   end

   // plain read of the stored value: a write in the same cycle is not seen
   assign rd_taken_o = ctr_q[rd_idx_i][CTR_W-1];

endmodule

// File: rtl/dbp_predict.sv
module dbp_predict
   import dbp_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic [1:0]    mode_i,
   input  logic          valid_i,
   input  logic [1:0]    kind_i,
   input  logic [AW-1:0] pc_i,
   input  logic [AW-1:0] imm_i,
   input  logic          hist_taken_i,
   output logic          pred_o,
   output logic          redir_o,
   output logic [AW-1:0] target_o,
   output logic          trap_o
);
   pred_mode_e mode;
   insn_kind_e kind;
   logic       misaligned;

   assign mode       = pred_mode_e'(mode_i);
   assign kind       = insn_kind_e'(kind_i);
   assign target_o   = pc_i + imm_i;
   assign misaligned = |target_o[1:0];

   always_comb begin
      pred_o = 1'b0;
      if (valid_i) begin
         unique case (mode)
            MODE_STATIC: begin
               if (kind == KIND_JAL)       pred_o = 1'b1;
               else if (kind == KIND_COND) pred_o = imm_i[AW-1];
            end
            MODE_DYNAMIC: begin
               if (kind == KIND_JAL)       pred_o = 1'b1;
               else if (kind == KIND_COND) pred_o = hist_taken_i;
            end
            default: pred_o = 1'b0;
         endcase
      end
   end

   assign trap_o  = pred_o & misaligned;
   assign redir_o = pred_o & ~misaligned;

endmodule

// File: rtl/dbp_resolve.sv
module dbp_resolve #(
   parameter int unsigned AW            = 32,
   parameter bit          EARLY_RESOLVE = 1'b0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          valid_i,
   input  logic [AW-1:0] pc_i,
   input  logic          taken_i,
   input  logic          pred_i,
   input  logic [AW-1:0] target_i,
   output logic          flush_o,
   output logic [AW-1:0] flush_pc_o,
   output logic          trap_o
);
   localparam logic [AW-1:0] STEP = AW'(4);

   logic          mispred, bad_tgt, flush_d, trap_d;
   logic [AW-1:0] next_pc;

   assign mispred = valid_i & (taken_i ^ pred_i);
   assign bad_tgt = taken_i & (|target_i[1:0]);
   assign flush_d = mispred & ~bad_tgt;
   assign trap_d  = mispred & bad_tgt;
   assign next_pc = taken_i ? target_i : pc_i + STEP;

   if (EARLY_RESOLVE) begin : g_early
      assign flush_o    = flush_d;
      assign trap_o     = trap_d;
      assign flush_pc_o = next_pc;
   end else begin : g_late
      logic          flush_q, trap_q;
      logic [AW-1:0] pc_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            flush_q <= 1'b0;
            trap_q  <= 1'b0;
            pc_q    <= '0;
         end else begin
            flush_q <= flush_d;
            trap_q  <= trap_d;
            pc_q    <= next_pc;
         end
      end
      assign flush_o    = flush_q;
      assign trap_o     = trap_q;
      assign flush_pc_o = pc_q;
   end

endmodule

// File: rtl/dec_branch_predictor.sv
module dec_branch_predictor #(
   parameter int unsigned AW            = 32,
   parameter int unsigned HIST_LOG2     = 6,
   parameter bit          EARLY_RESOLVE = 1'b0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [1:0]    mode_i,
   input  logic          dec_valid_i,
   input  logic [1:0]    dec_kind_i,
   input  logic [AW-1:0] dec_pc_i,
   input  logic [AW-1:0] dec_imm_i,
   output logic          redir_o,
   output logic [AW-1:0] redir_pc_o,
   output logic          pred_taken_o,
   output logic          trap_o,
   input  logic          rsv_valid_i,
   input  logic          rsv_cond_i,
   input  logic [AW-1:0] rsv_pc_i,
   input  logic          rsv_taken_i,
   input  logic          rsv_pred_i,
   input  logic [AW-1:0] rsv_target_i,
   output logic          flush_o,
   output logic [AW-1:0] flush_pc_o,
   output logic          rsv_trap_o
);
   localparam int unsigned IDX_LO = 2;
   localparam int unsigned IDX_HI = HIST_LOG2 + IDX_LO - 1;

   if (HIST_LOG2 < 1 || HIST_LOG2 > 12) begin : g_bad_depth
      $error("HIST_LOG2 must lie in 1..12");
   end
   if (AW < HIST_LOG2 + IDX_LO + 1) begin : g_bad_width
      $error("AW too narrow for the history index");
   end

   logic hist_taken;

   dbp_history #(.IDX_W(HIST_LOG2)) u_hist (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_idx_i   (dec_pc_i[IDX_HI:IDX_LO]),
      .rd_taken_o (hist_taken),
      .wr_en_i    (rsv_valid_i & rsv_cond_i),
      .wr_idx_i   (rsv_pc_i[IDX_HI:IDX_LO]),
      .wr_taken_i (rsv_taken_i)
   );

   dbp_predict #(.AW(AW)) u_pred (
      .mode_i       (mode_i),
      .valid_i      (dec_valid_i),
      .kind_i       (dec_kind_i),
      .pc_i         (dec_pc_i),
      .imm_i        (dec_imm_i),
      .hist_taken_i (hist_taken),
      .pred_o       (pred_taken_o),
      .redir_o      (redir_o),
      .target_o     (redir_pc_o),
      .trap_o       (trap_o)
   );

   dbp_resolve #(.AW(AW), .EARLY_RESOLVE(EARLY_RESOLVE)) u_rsv (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .valid_i    (rsv_valid_i),
      .pc_i       (rsv_pc_i),
      .taken_i    (rsv_taken_i),
      .pred_i     (rsv_pred_i),
      .target_i   (rsv_target_i),
      .flush_o    (flush_o),
      .flush_pc_o (flush_pc_o),
      .trap_o     (rsv_trap_o)
   );

endmodule

// File: rtl/dbp_checker.sv
module dbp_checker #(
   parameter int unsigned AW            = 32,
   parameter bit          EARLY_RESOLVE = 1'b0
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic [1:0]    mode_i,
   input logic          dec_valid_i,
   input logic [1:0]    dec_kind_i,
   input logic [AW-1:0] dec_pc_i,
   input logic [AW-1:0] dec_imm_i,
   input logic          redir_o,
   input logic [AW-1:0] redir_pc_o,
   input logic          pred_taken_o,
   input logic          trap_o,
   input logic          rsv_valid_i,
   input logic          rsv_taken_i,
   input logic          rsv_pred_i,
   input logic [AW-1:0] rsv_target_i,
   input logic          flush_o,
   input logic          rsv_trap_o
);
   logic off_mode, good_flush, matched;
   assign off_mode   = (mode_i == 2'd0) || (mode_i == 2'd3);
   assign good_flush = rsv_valid_i && (rsv_taken_i != rsv_pred_i)
                       && !(rsv_taken_i && (rsv_target_i[1:0] != 2'b00));
   assign matched    = !rsv_valid_i || (rsv_taken_i == rsv_pred_i);

   p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      off_mode |-> (!redir_o && !pred_taken_o && !trap_o));

   p_jal_steer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_valid_i && dec_kind_i == 2'd2 && (mode_i == 2'd1 || mode_i == 2'd2)
       && dec_pc_i[1:0] == 2'b00 && dec_imm_i[1:0] == 2'b00) |-> redir_o);

   p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!dec_valid_i || dec_kind_i == 2'd0 || dec_kind_i == 2'd3)
      |-> (!redir_o && !trap_o && !pred_taken_o));

   p_trap_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_o |-> !redir_o);

   p_aligned_redir_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      redir_o |-> (redir_pc_o[1:0] == 2'b00));

   if (EARLY_RESOLVE) begin : g_early_chk
      p_flush_now_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         good_flush |-> flush_o);
      p_match_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
         matched |-> (!flush_o && !rsv_trap_o));
   end else begin : g_late_chk
      p_flush_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         good_flush |=> flush_o);
      p_match_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
         matched |=> (!flush_o && !rsv_trap_o));
   end

endmodule

bind dec_branch_predictor dbp_checker #(.AW(AW), .EARLY_RESOLVE(EARLY_RESOLVE)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .mode_i       (mode_i),
   .dec_valid_i  (dec_valid_i),
   .dec_kind_i   (dec_kind_i),
   .dec_pc_i     (dec_pc_i),
   .dec_imm_i    (dec_imm_i),
   .redir_o      (redir_o),
   .redir_pc_o   (redir_pc_o),
   .pred_taken_o (pred_taken_o),
   .trap_o       (trap_o),
   .rsv_valid_i  (rsv_valid_i),
   .rsv_taken_i  (rsv_taken_i),
   .rsv_pred_i   (rsv_pred_i),
   .rsv_target_i (rsv_target_i),
   .flush_o      (flush_o),
   .rsv_trap_o   (rsv_trap_o)
);

// File: tb/dec_branch_predictor_tb.sv
`timescale 1ns/1ps
module dec_branch_predictor_tb;
   localparam int unsigned AW = 32;
   localparam int unsigned HL = 6;
   localparam int unsigned DEPTH = 1 << HL;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = '0;
   logic          dv = 1'b0;
   logic [1:0]    dk = '0;
   logic [AW-1:0] dpc = '0, dimm = '0;
   logic          redir, pred, trap;
   logic [AW-1:0] redir_pc;
   logic          rv = 1'b0, rc = 1'b0, rt = 1'b0, rp = 1'b0;
   logic [AW-1:0] rpc = '0, rtgt = '0;
   logic          flush, rtrap;
   logic [AW-1:0] flush_pc;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // reference state
   int unsigned   ctr_m [DEPTH];
   logic          exp_fl = 1'b0, exp_rtrap = 1'b0;
   logic [AW-1:0] exp_fpc = '0;

   always #2.5 clk = ~clk;

   dec_branch_predictor #(.AW(AW), .HIST_LOG2(HL), .EARLY_RESOLVE(1'b0)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
      .dec_valid_i(dv), .dec_kind_i(dk), .dec_pc_i(dpc), .dec_imm_i(dimm),
      .redir_o(redir), .redir_pc_o(redir_pc), .pred_taken_o(pred), .trap_o(trap),
      .rsv_valid_i(rv), .rsv_cond_i(rc), .rsv_pc_i(rpc), .rsv_taken_i(rt),
      .rsv_pred_i(rp), .rsv_target_i(rtgt),
      .flush_o(flush), .flush_pc_o(flush_pc), .rsv_trap_o(rtrap)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic exp_pred(input logic [1:0] m, input logic v, input logic [1:0] k,
                                     input logic [AW-1:0] pc, input logic [AW-1:0] imm);
      if (!v) return 1'b0;                                        // R4
      if (m == 2'd1) return (k == 2'd2) || (k == 2'd1 && imm[AW-1]); // R2 R3
      if (m == 2'd2) return (k == 2'd2) || (k == 2'd1 && ctr_m[pc[HL+1:2]] >= 2); // R5
      return 1'b0;                                                // R1
   endfunction

   // one cycle: check last cycle's flush, drive, check decode, update the model
   task automatic step(input logic [1:0] m, input logic v, input logic [1:0] k,
                       input logic [AW-1:0] pc, input logic [AW-1:0] imm,
                       input logic r_v, input logic r_c, input logic [AW-1:0] r_pc,
                       input logic r_t, input logic r_p, input logic [AW-1:0] r_tgt);
      logic          ep, mis, bad;
      logic [AW-1:0] tgt;
      @(negedge clk);
      check("R9 flush", {63'd0, flush}, {63'd0, exp_fl});
      check("R10 rsv_trap", {63'd0, rtrap}, {63'd0, exp_rtrap});
      if (exp_fl) check("R9 flush_pc", {32'd0, flush_pc}, {32'd0, exp_fpc});
      mode = m; dv = v; dk = k; dpc = pc; dimm = imm;
      rv = r_v; rc = r_c; rpc = r_pc; rt = r_t; rp = r_p; rtgt = r_tgt;
      #1;
      // decode checks use the counters before this cycle's write (R7)
      ep  = exp_pred(m, v, k, pc, imm);
      tgt = pc + imm;
      check("R2/R3/R5 pred_taken", {63'd0, pred}, {63'd0, ep});
      check("R8 trap", {63'd0, trap}, {63'd0, ep && (tgt[1:0] != 0)});
      check("R1/R4 redir", {63'd0, redir}, {63'd0, ep && (tgt[1:0] == 0)});
      if (redir) check("R2/R3 redir_pc", {32'd0, redir_pc}, {32'd0, tgt});
      mis       = r_v && (r_t != r_p);
      bad       = r_t && (r_tgt[1:0] != 0);
      exp_fl    = mis && !bad;                                    // R9 R11
      exp_rtrap = mis && bad;                                     // R10
      exp_fpc   = r_t ? r_tgt : r_pc + 32'd4;
      if (r_v && r_c) begin                                       // R6
         if (r_t) begin
            if (ctr_m[r_pc[HL+1:2]] < 3) ctr_m[r_pc[HL+1:2]]++;
         end else begin
            if (ctr_m[r_pc[HL+1:2]] > 0) ctr_m[r_pc[HL+1:2]]--;
         end
      end
   endtask

   task automatic idle();
      step(2'd0, 1'b0, 2'd0, '0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] lp;
      void'($urandom(32'd2718));
      for (int i = 0; i < DEPTH; i++) ctr_m[i] = 1;               // R5 reset value 01
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R11 reset flush", {63'd0, flush}, 64'd0);
      check("R1 reset redir", {63'd0, redir}, 64'd0);

      // R1: off and reserved modes stay quiet for a JAL and a backward branch
      step(2'd0, 1'b1, 2'd2, 32'h100, 32'h40, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
      step(2'd3, 1'b1, 2'd1, 32'h100, -32'sd8, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
      // R2: backward taken, forward not taken
      step(2'd1, 1'b1, 2'd1, 32'h200, -32'sd16, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
      step(2'd1, 1'b1, 2'd1, 32'h200, 32'd16, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
      // R3 JAL, R4 class other and invalid slot
      step(2'd2, 1'b1, 2'd2, 32'h300, 32'h800, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
      step(2'd1, 1'b1, 2'd0, 32'h300, -32'sd4, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
      step(2'd1, 1'b0, 2'd2, 32'h300, 32'h8, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
      // R8: JAL to a misaligned target traps
      step(2'd1, 1'b1, 2'd2, 32'h400, 32'h6, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0);

      // R5 R6 R7 loop: same branch taken repeatedly, decode of the same PC in the write cycle
      lp = 32'h1040;
      for (int i = 0; i < 5; i++)
         step(2'd2, 1'b1, 2'd1, lp, -32'sd32, 1'b1, 1'b1, lp, 1'b1, 1'b0, lp - 32'd32);
      for (int i = 0; i < 5; i++)
         step(2'd2, 1'b1, 2'd1, lp, -32'sd32, 1'b1, 1'b1, lp, 1'b0, 1'b1, lp - 32'd32);
      // R6: non-conditional resolve does not touch the counter
      for (int i = 0; i < 3; i++)
         step(2'd2, 1'b1, 2'd1, lp, -32'sd32, 1'b1, 1'b0, lp, 1'b1, 1'b1, lp - 32'd32);
      step(2'd2, 1'b1, 2'd1, lp, -32'sd32, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0);

      // R10: mispredicted taken to misaligned target, then R9 not-taken fall-through
      step(2'd0, 1'b0, 2'd0, '0, '0, 1'b1, 1'b1, 32'h500, 1'b1, 1'b0, 32'h502);
      step(2'd0, 1'b0, 2'd0, '0, '0, 1'b1, 1'b1, 32'h600, 1'b0, 1'b1, 32'h700);
      idle();

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [AW-1:0] p, im, q;
         p  = {22'd0, $urandom_range(1023, 0), 2'b00};
         im = ($urandom_range(9, 0) == 0) ? AW'($urandom_range(7, 1) * 2)
                                          : AW'(($urandom_range(64, 0) - 32) * 4);
         q  = {22'd0, $urandom_range(1023, 0), 2'b00};
         step(2'($urandom_range(3, 0)), 1'($urandom_range(1, 0)), 2'($urandom_range(3, 0)), p, im,
              1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), q,
              1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
              ($urandom_range(7, 0) == 0) ? q + 32'd2 : q + 32'h40);
      end
      idle();
      idle();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule